// File: doc/BRIEF.md
# CAN Error and Overload Frame Generator

This block sits next to a CAN protocol engine and takes over the transmit bit whenever an error frame or an overload frame has to be sent. It works one bit at a time. It acts only when the protocol engine's sample-point strobe is high, and it reads the sampled bus level on that strobe. When the engine reports a bus error, the block sends a flag that matches the node's fault state. It then waits while other nodes add their own flags, counts the delimiter, and at the end tells the engine whether the aborted message has to be sent again. During interframe space it also sends overload frames. An overload frame starts when a dominant bit is sampled or when the node asks for more time. At most two overload frames may follow one another.

The bus level is 1 for recessive and 0 for dominant on both `rx_bit` and `tx_bit`. The block has no streaming data path. All pins are plain control and status levels or one-clock pulses, so there is no valid/ready handshake and no back-pressure. The error-passive status and the ownership of the current message are inputs. The block latches both when an error frame starts.

Top module: `can_eo_gen`

## Requirements
- R1: A synchronous reset puts the block in idle. After reset `tx_bit` is 1 (recessive), `busy`, `frame_done`, `retx_req` and `flag_overflow` are 0, and the count of back-to-back overload frames is zero.
- R2: State changes only on a clock where `bit_tick` is 1. Inputs held while `bit_tick` is 0 change neither `tx_bit` nor `busy`.
- R3: Suppose the block is idle and not passive, and `err_det` is 1 on a strobe. Then `busy` rises and `tx_bit` is 0 for the next 6 bit periods. After that `tx_bit` is 1.
- R4: After its own 6-bit flag, the block keeps `tx_bit` recessive while the bus stays dominant. The first recessive sample is delimiter bit 1. `frame_done` pulses for one clock after the strobe that samples delimiter bit 8. If the bus is dominant for 6+E flag bits, the frame lasts 6+E+8 strobes.
- R5: If the bus is dominant on more than 12 consecutive strobes inside a frame, `flag_overflow` goes to 1. It stays at 1 until the next frame starts, and the start of that frame clears it.
- R6: In a frame started with `err_passive` = 1, `tx_bit` stays 1 for the whole frame. If the bus is recessive throughout, `frame_done` pulses after 14 strobes.
- R7: If a dominant bit is sampled during the delimiter, the delimiter count starts again. The frame then ends only after 8 more recessive samples in a row.
- R8: After a passive error frame, `busy` stays 1 until the block has sampled 6 recessive bits in a row. A dominant sample resets that count to zero.
- R9: `retx_req` pulses for one clock when an error frame ends, but only if `msg_owner` was 1 on the strobe that started the frame. For an active node this happens together with `frame_done`. For a passive node it happens at the end of the rejoin wait. Overload frames never raise `retx_req`.
- R10: Suppose the block is idle with `in_ifs` = 1, and on a strobe either `rx_bit` is 0 or `not_ready` is 1. Then the block sends an overload frame: 6 dominant bits, followed by the same delimiter handling as an error frame.
- R11: Only 2 overload frames may be sent in a row. A further trigger is ignored and `busy` stays 0. A strobe taken in idle with `in_ifs` = 0 clears the count.
- R12: If an error and an overload trigger occur on the same strobe, the error frame wins. `err_det` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Sample-point strobe, one clock per bit |
| rx_bit | input | 1 | Sampled bus level (1 = recessive) |
| err_det | input | 1 | Bus error detected |
| err_passive | input | 1 | Node is error-passive |
| msg_owner | input | 1 | Node is the transmitter of the current message |
| in_ifs | input | 1 | Bus is in interframe space |
| not_ready | input | 1 | Internal request to delay the next message |
| tx_bit | output | 1 | Transmit bit (0 = dominant) |
| busy | output | 1 | An error or overload frame (or rejoin wait) is in progress |
| frame_done | output | 1 | One-clock pulse when the delimiter completes |
| retx_req | output | 1 | One-clock pulse requesting resend of the aborted message |
| flag_overflow | output | 1 | Dominant run longer than 12 bits seen in this frame |

## Verification
Error frames are swept over both fault states, both values of message ownership, and a number of added dominant bits from 0 to 8. The frame length shows whether superposed flags are tolerated. The sweep past 12 dominant bits separates a run that is allowed from one that overflows. Ownership separates the cases that request a retransmit from those that do not. Separate patterns cover:
- a dominant spike inside the delimiter, which shows the delimiter count restarting;
- a dominant bit during the rejoin wait, which shows the rejoin count resetting;
- three overload triggers in a row, which show where the limit of two applies;
- a trigger after interframe space has been left, which shows the overload count being cleared;
- an error and an overload trigger on the same strobe, which shows the priority.

// File: rtl/can_eo_pkg.sv
package can_eo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FLAG   = 3'd1,
    ST_SUPER  = 3'd2,
    ST_DELIM  = 3'd3,
    ST_REJOIN = 3'd4
  } eo_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/can_eo_trigger.sv
// Decides when a frame starts and enforces the back-to-back overload limit.
module can_eo_trigger #(
  parameter int MAX_OVL = 2,
  localparam int OW = $clog2(MAX_OVL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          idle,
  input  logic          rx_bit,
  input  logic          err_det,
  input  logic          in_ifs,
  input  logic          not_ready,
  output logic          start_err,
  output logic          start_ovl,
  output logic [OW-1:0] ovl_count
);
  logic ovl_want;
  logic ovl_room;

  assign ovl_want  = in_ifs && (!rx_bit || not_ready);
  assign ovl_room  = ovl_count < OW'(MAX_OVL);
  assign start_err = bit_tick && idle && err_det;
  assign start_ovl = bit_tick && idle && !err_det && ovl_want && ovl_room;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_count <= '0;
    end else if (bit_tick && idle) begin
      if (!in_ifs)        ovl_count <= '0;
      else if (start_ovl) ovl_count <= ovl_count + OW'(1);
    end
  end
endmodule

// File: rtl/can_eo_runmon.sv
// Tracks consecutive dominant samples inside a frame and flags an overlong run.
module can_eo_runmon #(
  parameter int MAX_RUN = 12,
  localparam int RW = $clog2(MAX_RUN + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic clear,
  input  logic track,
  input  logic rx_bit,
  output logic overflow
);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= '0;
      overflow <= 1'b0;
    end else if (bit_tick) begin
      if (clear) begin
        run      <= '0;
        overflow <= 1'b0;
      end else if (track) begin
        if (!rx_bit) begin
          if (run <= RW'(MAX_RUN)) run <= run + RW'(1);
          if (run >= RW'(MAX_RUN)) overflow <= 1'b1;
        end else begin
          run <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/can_eo_seq.sv
// Bit-level sequencer: flag, superposition wait, delimiter, passive rejoin wait.
module can_eo_seq
  import can_eo_pkg::*;
#(
  parameter int FLAG_LEN   = 6,
  parameter int DELIM_LEN  = 8,
  parameter int REJOIN_LEN = 6,
  localparam int CMAX = max3(FLAG_LEN, DELIM_LEN, REJOIN_LEN),
  localparam int CW   = $clog2(CMAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic start_err,
  input  logic start_ovl,
  input  logic err_passive,
  input  logic msg_owner,
  output logic tx_bit,
  output logic busy,
  output logic in_frame,
  output logic frame_done,
  output logic retx_req,
  output logic passive_q
);
  eo_state_e     state;
  logic [CW-1:0] cnt;
  logic          kind_err;
  logic          owner_q;

  assign tx_bit   = !(state == ST_FLAG && !passive_q);
  assign busy     = state != ST_IDLE;
  assign in_frame = state == ST_FLAG || state == ST_SUPER || state == ST_DELIM;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      kind_err   <= 1'b0;
      passive_q  <= 1'b0;
      owner_q    <= 1'b0;
      frame_done <= 1'b0;
      retx_req   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      retx_req   <= 1'b0;
      if (bit_tick) begin
        case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (start_err) begin
              state     <= ST_FLAG;
              kind_err  <= 1'b1;
              passive_q <= err_passive;
              owner_q   <= msg_owner;
            end else if (start_ovl) begin
              state     <= ST_FLAG;
              kind_err  <= 1'b0;
              passive_q <= 1'b0;
              owner_q   <= 1'b0;
            end
          end
          ST_FLAG: begin
            if (cnt == CW'(FLAG_LEN - 1)) begin
              state <= ST_SUPER;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_SUPER: begin
            if (rx_bit) begin
              state <= ST_DELIM;
              cnt   <= CW'(1);
            end
          end
          ST_DELIM: begin
            if (!rx_bit) begin
              state <= ST_SUPER;
              cnt   <= '0;
            end else if (cnt == CW'(DELIM_LEN - 1)) begin
              frame_done <= 1'b1;
              cnt        <= '0;
              if (kind_err && passive_q) begin
                state <= ST_REJOIN;
              end else begin
                state    <= ST_IDLE;
                retx_req <= kind_err && owner_q;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_REJOIN: begin
            if (!rx_bit) begin
              cnt <= '0;
            end else if (cnt == CW'(REJOIN_LEN - 1)) begin
              state    <= ST_IDLE;
              cnt      <= '0;
              retx_req <= owner_q;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: begin
            state <= ST_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/can_eo_gen.sv
module can_eo_gen #(
  parameter int FLAG_LEN   = 6,
  parameter int DELIM_LEN  = 8,
  parameter int REJOIN_LEN = 6,
  parameter int MAX_RUN    = 12,
  parameter int MAX_OVL    = 2,
  localparam int OVL_W     = $clog2(MAX_OVL + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic err_det,
  input  logic err_passive,
  input  logic msg_owner,
  input  logic in_ifs,
  input  logic not_ready,
  output logic tx_bit,
  output logic busy,
  output logic frame_done,
  output logic retx_req,
  output logic flag_overflow
);
  logic             start_err;
  logic             start_ovl;
  logic             in_frame;
  logic             passive_q;
  logic [OVL_W-1:0] ovl_count;

  can_eo_trigger #(.MAX_OVL(MAX_OVL)) u_trig (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .idle(!busy),
    .rx_bit(rx_bit), .err_det(err_det), .in_ifs(in_ifs),
    .not_ready(not_ready), .start_err(start_err), .start_ovl(start_ovl),
    .ovl_count(ovl_count)
  );

  can_eo_seq #(
    .FLAG_LEN(FLAG_LEN), .DELIM_LEN(DELIM_LEN), .REJOIN_LEN(REJOIN_LEN)
  ) u_seq (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .start_err(start_err), .start_ovl(start_ovl),
    .err_passive(err_passive), .msg_owner(msg_owner),
    .tx_bit(tx_bit), .busy(busy), .in_frame(in_frame),
    .frame_done(frame_done), .retx_req(retx_req), .passive_q(passive_q)
  );

  can_eo_runmon #(.MAX_RUN(MAX_RUN)) u_run (
    .clk(clk), .rst(rst), .bit_tick(bit_tick),
    .clear(start_err || start_ovl), .track(in_frame),
    .rx_bit(rx_bit), .overflow(flag_overflow)
  );
endmodule

// File: rtl/can_eo_gen_chk.sv
module can_eo_gen_chk #(
  parameter int MAX_OVL = 2,
  parameter int OCW     = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           bit_tick,
  input logic           tx_bit,
  input logic           busy,
  input logic           frame_done,
  input logic           retx_req,
  input logic           flag_overflow,
  input logic           passive_q,
  input logic [OCW-1:0] ovl_count
);
  // R1 / R3: recessive whenever no frame is running
  p_idle_recessive_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_bit);

  // R2: nothing moves between strobes
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> ($stable(tx_bit) && $stable(busy)));

  // R3 / R10: an active frame opens with a dominant bit
  p_flag_dominant_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !passive_q) |-> !tx_bit);

  // R5: each new frame starts with a cleared overflow status
  p_ovf_cleared_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !flag_overflow);

  // R6: a passive frame never drives dominant
  p_passive_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && passive_q) |-> tx_bit);

  // R4: completion is a single-clock pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R9: retransmit is a single-clock pulse
  p_retx_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    retx_req |=> !retx_req);

  // R11: overload count never exceeds the limit
  p_ovl_limit_r11: assert property (@(posedge clk) disable iff (rst)
    ovl_count <= OCW'(MAX_OVL));
endmodule

bind can_eo_gen can_eo_gen_chk #(.MAX_OVL(MAX_OVL), .OCW(OVL_W)) u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_bit(tx_bit), .busy(busy),
  .frame_done(frame_done), .retx_req(retx_req),
  .flag_overflow(flag_overflow), .passive_q(passive_q), .ovl_count(ovl_count)
);

// File: tb/can_eo_gen_test.sv
`timescale 1ns/1ps
module can_eo_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, rx_bit = 1'b1, err_det = 1'b0, err_passive = 1'b0;
  logic msg_owner = 1'b0, in_ifs = 1'b0, not_ready = 1'b0;
  logic tx_bit, busy, frame_done, retx_req, flag_overflow;

  int n_cmp = 0;
  int n_bad = 0;
  logic tx_seen;
  bit done_flag;

  always #2.5 clk = ~clk;

  can_eo_gen uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .err_det(err_det), .err_passive(err_passive), .msg_owner(msg_owner),
    .in_ifs(in_ifs), .not_ready(not_ready), .tx_bit(tx_bit), .busy(busy),
    .frame_done(frame_done), .retx_req(retx_req),
    .flag_overflow(flag_overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe: tx_seen is the bit driven during that bit period
  task automatic step(input logic rx);
    @(negedge clk);
    rx_bit   = rx;
    tx_seen  = tx_bit;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    err_det  = 1'b0;
    rx_bit   = 1'b1;
  endtask

  // error frame: E extra dominant bits after the flag
  task automatic err_frame(input bit passv, input bit own, input int e);
    int  n;
    int  len;
    bit  got_done;
    bit  got_retx;
    bit  tx_ok;
    err_passive = passv; msg_owner = own; err_det = 1'b1;
    step(1'b1);
    chk("R3 busy after error strobe", busy, 1);
    n = 0; got_done = 0; got_retx = 0; tx_ok = 1; len = 0;
    while (!got_done && n < 60) begin
      logic bus;
      n++;
      if (passv) bus = (n > 6 && n <= 6 + e) ? 1'b0 : 1'b1;
      else       bus = (n <= 6 + e) ? 1'b0 : 1'b1;
      step(bus);
      if (tx_seen != ((n <= 6 && !passv) ? 1'b0 : 1'b1)) tx_ok = 0;
      if (frame_done) begin got_done = 1; len = n; end
      if (retx_req) got_retx = 1;
    end
    chk(passv ? "R6 passive tx stays recessive" : "R3 flag bits dominant", tx_ok, 1);
    chk(passv ? "R6 passive frame length" : "R4 frame length", len, 14 + e);
    chk("R5 overflow status", flag_overflow, (!passv && 6 + e > 12) ? 1 : 0);
    if (!passv) begin
      chk("R9 active retransmit with done", got_retx, own);
      chk("R4 idle after active frame", busy, 0);
    end else begin
      chk("R9 no retransmit before rejoin", got_retx, 0);
      chk("R8 busy during rejoin", busy, 1);
      got_retx = 0;
      for (int k = 1; k <= 6; k++) begin
        step(1'b1);
        if (retx_req) got_retx = 1;
        if (k < 6) chk("R8 still waiting", busy, 1);
      end
      chk("R8 rejoin after 6 recessive", busy, 0);
      chk("R9 passive retransmit after rejoin", got_retx, own);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx after reset", tx_bit, 1);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", frame_done, 0);
    chk("R1 retx after reset", retx_req, 0);
    chk("R1 overflow after reset", flag_overflow, 0);

    // R2: triggers without a strobe do nothing
    err_det = 1'b1; in_ifs = 1'b1; not_ready = 1'b1; rx_bit = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 no start without tick", busy, 0);
    chk("R2 tx unchanged without tick", tx_bit, 1);
    err_det = 1'b0; in_ifs = 1'b0; not_ready = 1'b0; rx_bit = 1'b1;

    // sweep: fault state x ownership x superposed dominant bits
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 2; o++)
        for (int e = 0; e <= 8; e++)
          err_frame(p[0], o[0], e);

    // R7: dominant spike inside the delimiter restarts the count
    begin
      int n; int len;
      err_passive = 0; msg_owner = 0; err_det = 1;
      step(1'b1);
      n = 0; len = 0;
      while (len == 0 && n < 60) begin
        n++;
        step((n <= 6 || n == 10) ? 1'b0 : 1'b1);
        if (frame_done) len = n;
      end
      chk("R7 delimiter restart length", len, 18);
    end

    // R8: dominant bit during rejoin resets the count
    begin
      int n;
      err_passive = 1; msg_owner = 1; err_det = 1;
      step(1'b1);
      for (int k = 1; k <= 14; k++) step(1'b1);
      step(1'b1); step(1'b1); step(1'b0);
      n = 0;
      while (busy && n < 20) begin n++; step(1'b1); end
      chk("R8 rejoin count restarted", n, 6);
      err_passive = 0;
    end

    // R10 / R11: three not-ready requests in interframe space
    in_ifs = 1; not_ready = 1;
    for (int f = 0; f < 3; f++) begin
      int len; bit tx_ok; bit got_retx;
      step(1'b1);
      if (f < 2) begin
        chk("R10 overload started", busy, 1);
        len = 0; tx_ok = 1; got_retx = 0;
        for (int n = 1; n <= 14; n++) begin
          step(n <= 6 ? 1'b0 : 1'b1);
          if (tx_seen != (n <= 6 ? 1'b0 : 1'b1)) tx_ok = 0;
          if (frame_done) len = n;
          if (retx_req) got_retx = 1;
        end
        chk("R10 overload flag pattern", tx_ok, 1);
        chk("R10 overload length", len, 14);
        chk("R10 no retransmit for overload", got_retx, 0);
      end else begin
        chk("R11 third overload ignored", busy, 0);
        chk("R11 tx recessive when ignored", tx_bit, 1);
      end
    end
    // R11: dominant trigger also blocked at the limit
    step(1'b0);
    chk("R11 dominant trigger blocked", busy, 0);
    // R11: leaving interframe space clears the count
    in_ifs = 0; not_ready = 0;
    step(1'b1);
    chk("R11 no start outside ifs", busy, 0);
    in_ifs = 1;
    step(1'b0);
    chk("R10 dominant in ifs starts overload", busy, 1);
    for (int n = 1; n <= 14; n++) step(n <= 6 ? 1'b0 : 1'b1);
    chk("R10 overload finished", busy, 0);

    // R12: error wins over overload on the same strobe
    begin
      bit got_retx;
      in_ifs = 0; step(1'b1);
      in_ifs = 1; not_ready = 1; msg_owner = 1; err_passive = 0; err_det = 1;
      step(1'b1);
      chk("R12 frame started", busy, 1);
      not_ready = 0; in_ifs = 0;
      got_retx = 0;
      for (int n = 1; n <= 14; n++) begin
        if (n == 3) err_det = 1;
        step(n <= 6 ? 1'b0 : 1'b1);
        if (retx_req) got_retx = 1;
      end
      chk("R12 error frame chosen (retransmit)", got_retx, 1);
      chk("R12 err_det while busy ignored", busy, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule